// File: doc/BRIEF.md
# Parallel SAR ADC read sequencer

This block paces a successive-approximation converter with a parallel data bus from a synchronous clock. A single active-low strobe does two jobs: it makes the converter put the previous conversion's result on its data pins, and it starts the next conversion. Every word that comes out therefore belongs to the strobe before the one that fetched it. The sequencer reads that word once the bus has had time to settle, then releases the strobe and hands the word downstream with a one-cycle valid pulse.

Two bus widths are supported, chosen per read. In wide mode all 16 bits are captured in one sample and the half-select output stays low. In narrow mode only the low 8 pins carry data. The high half is read first with the half-select high. The select is then dropped, and after a longer settle wait the low half is read. The word is assembled as {high, low}. The pace between strobes is a fixed interval that depends on the speed mode (normal or fast). It can instead follow the converter's BUSY line. In fast mode, a gap longer than a configured limit raises an error flag.

All timing is given in nanoseconds and converted to clock cycles, rounding up, when the block is elaborated.

Top module: `adc_read_seq`

## Requirements
- R1: Each word presented with `sampleValid` equals the result of the conversion started by the strobe before the one that read it.
- R2: The read made by the first strobe after reset produces no `sampleValid` pulse.
- R3: In wide mode (`byteMode`=0) the bus is sampled STB_CYC cycles after `cnvRdN` falls. `cnvRdN` rises on that same edge, and `sampleValid` is high in the following cycle.
- R4: In narrow mode (`byteMode`=1), `byteSel` is 1 when `cnvRdN` falls, and `dataIn[7:0]` is taken as the high half STB_CYC cycles later. On that edge `byteSel` drops to 0. `dataIn[7:0]` is taken as the low half BSEL_CYC cycles after that, when `cnvRdN` rises and `byteSel` returns to 1. The output is {high, low}.
- R5: In wide mode `byteSel` stays 0 throughout the read.
- R6: With `busyEn`=0 and `fastMode`=0, successive falls of `cnvRdN` are exactly NORM_CYC cycles apart.
- R7: With `busyEn`=0 and `fastMode`=1, successive falls of `cnvRdN` are exactly FAST_CYC cycles apart.
- R8: With `busyEn`=1, the next strobe falls on the first clock edge at which `busy` is low and at least BLANK_CYC cycles have passed since the previous fall. The fixed interval is not used.
- R9: In fast mode `intervalErr` rises MAXGAP_CYC+1 cycles after the last fall of `cnvRdN` if no strobe has followed. It is cleared on the edge that issues the next strobe and is never raised while `fastMode`=0.
- R10: `sampleValid` is a single-cycle pulse per read.
- R11: During reset `cnvRdN`=1, `byteSel`=0, `sampleValid`=0, `intervalErr`=0 and `sampleData`=0.
- R12: While `enable`=0 no new strobe is issued, although a read already in progress completes.
- R13: Each cycle count is its nanosecond parameter divided by CLK_NS, rounded up. With the defaults this gives STB_CYC=2, BSEL_CYC=4, NORM_CYC=125, FAST_CYC=100, MAXGAP_CYC=300 and BLANK_CYC=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new strobes |
| byteMode | input | 1 | 1: 8-bit bus, two reads per word; 0: 16-bit bus |
| fastMode | input | 1 | Selects the short conversion interval and the gap check |
| busyEn | input | 1 | Pace strobes from `busy` instead of the fixed interval |
| busy | input | 1 | Conversion in progress, from the converter |
| dataIn | input | DATA_W | Converter data pins |
| cnvRdN | output | 1 | Combined convert-start and read strobe, active low |
| byteSel | output | 1 | Half select: 1 = high half, 0 = low half |
| sampleValid | output | 1 | One-cycle pulse with a new word |
| sampleData | output | DATA_W | Assembled result |
| intervalErr | output | 1 | Fast-mode gap limit exceeded |

## Verification
All timing is measured from the cycle in which the strobe is first seen low. A wide read's word and valid pulse are due STB_CYC cycles later. A narrow read's select drop is due STB_CYC cycles later and its word BSEL_CYC cycles after that. The bench samples every output on falling clock edges at exactly those cycle offsets, so each register stage is counted once. Strobe spacing, the busy-paced interval, and the MAXGAP_CYC and MAXGAP_CYC+1 boundaries of the error flag are checked against the posedge count recorded when each strobe is detected. The converter model corrupts the bus until its settle time has passed, so a sample taken one cycle early reads junk.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FIRST  = 2'd1,
    SEQ_SECOND = 2'd2
  } seqState_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic latchHi;     // narrow mode: store the high half
    logic finishWord;  // wide mode: take the whole bus
    logic finishByte;  // narrow mode: take the low half and assemble
    logic publish;     // raise sampleValid with this word
  } seqStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int atLeastOne(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int STB_CYC    = 2,
  parameter int BSEL_CYC   = 4,
  parameter int NORM_CYC   = 125,
  parameter int FAST_CYC   = 100,
  parameter int MAXGAP_CYC = 300,
  parameter int BLANK_CYC  = 2,
  parameter int CNT_W      = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       byteMode,
  input  logic       fastMode,
  input  logic       busyEn,
  input  logic       busy,
  output logic       cnvRdN,
  output logic       byteSel,
  output logic       intervalErr,
  output seqStrobe_t ctl
);

  localparam int WAIT_MAX = (STB_CYC > BSEL_CYC) ? STB_CYC : BSEL_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int AGE_W    = $clog2(BSEL_CYC + 1);

  localparam logic [WAIT_W-1:0] STB_LD   = WAIT_W'(STB_CYC - 1);
  localparam logic [WAIT_W-1:0] BSEL_LD  = WAIT_W'(BSEL_CYC - 1);
  localparam logic [AGE_W-1:0]  AGE_SAT  = AGE_W'(BSEL_CYC);
  localparam logic [CNT_W-1:0]  NORM_M1  = CNT_W'(NORM_CYC - 1);
  localparam logic [CNT_W-1:0]  FAST_M1  = CNT_W'(FAST_CYC - 1);
  localparam logic [CNT_W-1:0]  BLANK_M1 = CNT_W'(BLANK_CYC - 1);
  localparam logic [CNT_W-1:0]  GAP_LIM  = CNT_W'(MAXGAP_CYC);
  localparam logic [CNT_W-1:0]  CNT_SAT  = {CNT_W{1'b1}};

  seqState_t         state;
  logic [WAIT_W-1:0] waitCnt;
  logic [CNT_W-1:0]  sinceCnt;
  logic [AGE_W-1:0]  bselAge;
  logic              started;
  logic              primed;
  logic              curByte;
  logic              cnvRdNq;
  logic              byteSelq;
  logic              errQ;

  logic              waitDone;
  logic              intervalMet;
  logic              bselReady;
  logic              go;
  logic              byteSelNext;
  logic [CNT_W-1:0]  periodM1;

  assign cnvRdN      = cnvRdNq;
  assign byteSel     = byteSelq;
  assign intervalErr = errQ;

  // ---------------- pacing ----------------
  always_comb begin
    waitDone    = (waitCnt == '0);
    periodM1    = fastMode ? FAST_M1 : NORM_M1;
    intervalMet = busyEn ? ((sinceCnt >= BLANK_M1) && !busy)
                         : (sinceCnt >= periodM1);
    bselReady   = (byteSelq == byteMode) && (bselAge >= AGE_SAT);
    go          = (state == SEQ_IDLE) && enable && bselReady
                  && (!started || intervalMet);
  end

  // ---------------- strobes to datapath ----------------
  always_comb begin
    ctl = '0;
    if (state == SEQ_FIRST && waitDone) begin
      ctl.latchHi    = curByte;
      ctl.finishWord = !curByte;
      ctl.publish    = !curByte && primed;
    end else if (state == SEQ_SECOND && waitDone) begin
      ctl.finishByte = 1'b1;
      ctl.publish    = primed;
    end
  end

  // ---------------- half select next value ----------------
  always_comb begin
    byteSelNext = byteSelq;
    unique case (state)
      SEQ_IDLE:   byteSelNext = byteMode;
      SEQ_FIRST:  if (waitDone && curByte) byteSelNext = 1'b0;
      SEQ_SECOND: if (waitDone) byteSelNext = 1'b1;
      default:    byteSelNext = byteSelq;
    endcase
  end

  // ---------------- sequencer ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      waitCnt  <= '0;
      started  <= 1'b0;
      primed   <= 1'b0;
      curByte  <= 1'b0;
      cnvRdNq  <= 1'b1;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (go) begin
            state   <= SEQ_FIRST;
            cnvRdNq <= 1'b0;
            waitCnt <= STB_LD;
            started <= 1'b1;
            curByte <= byteMode;
          end
        end
        SEQ_FIRST: begin
          if (!waitDone) begin
            waitCnt <= waitCnt - 1'b1;
          end else if (curByte) begin
            state   <= SEQ_SECOND;
            waitCnt <= BSEL_LD;
          end else begin
            state   <= SEQ_IDLE;
            cnvRdNq <= 1'b1;
            primed  <= 1'b1;
          end
        end
        SEQ_SECOND: begin
          if (!waitDone) begin
            waitCnt <= waitCnt - 1'b1;
          end else begin
            state   <= SEQ_IDLE;
            cnvRdNq <= 1'b1;
            primed  <= 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // ---------------- timers and select ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceCnt <= '0;
      bselAge  <= AGE_SAT;
      byteSelq <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      if (go)
        sinceCnt <= '0;
      else if (sinceCnt != CNT_SAT)
        sinceCnt <= sinceCnt + 1'b1;

      byteSelq <= byteSelNext;
      if (byteSelNext != byteSelq)
        bselAge <= '0;
      else if (bselAge < AGE_SAT)
        bselAge <= bselAge + 1'b1;

      if (go)
        errQ <= 1'b0;
      else if (fastMode && started && (sinceCnt >= GAP_LIM))
        errQ <= 1'b1;
    end
  end

  // ---------------- strobe spacing monitor ----------------
  logic             prevRd;
  logic             hadFall;
  logic             fallSeen;
  logic [CNT_W-1:0] gapCnt;

  assign fallSeen = prevRd && !cnvRdNq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRd  <= 1'b1;
      hadFall <= 1'b0;
      gapCnt  <= '0;
    end else begin
      prevRd <= cnvRdNq;
      if (fallSeen) begin
        hadFall <= 1'b1;
        gapCnt  <= CNT_W'(1);
      end else if (gapCnt != CNT_SAT) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  // R6/R7: fixed pacing never spaces strobes closer than the fast interval
  p_min_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fallSeen && hadFall && !$past(busyEn)) |-> (gapCnt >= CNT_W'(FAST_CYC)));

  // R9: the error flag is clear in the cycle a new strobe appears
  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cnvRdNq) |-> !errQ);

  // R5: wide reads keep the half select low
  p_word_sel_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state != SEQ_IDLE && !curByte) |-> !byteSelq);

  // R4: the narrow read starts with the high half selected
  p_hi_sel_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cnvRdNq) && curByte |-> byteSelq);

endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        ctl,
  input  logic [DATA_W-1:0] dataIn,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData
);

  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] hiReg;
  logic              hiFresh;
  logic [DATA_W-1:0] narrowWord;

  assign narrowWord = {hiReg, dataIn[HALF_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg       <= '0;
      hiFresh     <= 1'b0;
      sampleData  <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= (ctl.finishWord || ctl.finishByte) && ctl.publish;
      if (ctl.latchHi) begin
        hiReg   <= dataIn[HALF_W-1:0];
        hiFresh <= 1'b1;
      end
      if (ctl.finishWord)
        sampleData <= dataIn;
      if (ctl.finishByte) begin
        sampleData <= narrowWord;
        hiFresh    <= 1'b0;
      end
    end
  end

  // R4: the low half is only taken after a high half of the same read
  p_hi_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finishByte |-> hiFresh);

  // R10: one pulse per read
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 10,
  parameter int STB_NS    = 15,
  parameter int BSEL_NS   = 40,
  parameter int NORM_NS   = 1250,
  parameter int FAST_NS   = 1000,
  parameter int MAXGAP_NS = 3000,
  parameter int BLANK_NS  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              byteMode,
  input  logic              fastMode,
  input  logic              busyEn,
  input  logic              busy,
  input  logic [DATA_W-1:0] dataIn,
  output logic              cnvRdN,
  output logic              byteSel,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData,
  output logic              intervalErr
);

  localparam int STB_CYC    = atLeastOne(ceilDiv(STB_NS, CLK_NS));
  localparam int BSEL_CYC   = atLeastOne(ceilDiv(BSEL_NS, CLK_NS));
  localparam int NORM_CYC   = atLeastOne(ceilDiv(NORM_NS, CLK_NS));
  localparam int FAST_CYC   = atLeastOne(ceilDiv(FAST_NS, CLK_NS));
  localparam int MAXGAP_CYC = atLeastOne(ceilDiv(MAXGAP_NS, CLK_NS));
  localparam int BLANK_CYC  = atLeastOne(ceilDiv(BLANK_NS, CLK_NS));
  localparam int CNT_W      = $clog2(MAXGAP_CYC + NORM_CYC + FAST_CYC + 2);

  seqStrobe_t ctl;

  adc_seq_ctrl #(
    .STB_CYC   (STB_CYC),
    .BSEL_CYC  (BSEL_CYC),
    .NORM_CYC  (NORM_CYC),
    .FAST_CYC  (FAST_CYC),
    .MAXGAP_CYC(MAXGAP_CYC),
    .BLANK_CYC (BLANK_CYC),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .byteMode   (byteMode),
    .fastMode   (fastMode),
    .busyEn     (busyEn),
    .busy       (busy),
    .cnvRdN     (cnvRdN),
    .byteSel    (byteSel),
    .intervalErr(intervalErr),
    .ctl        (ctl)
  );

  adc_seq_datapath #(
    .DATA_W(DATA_W)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .dataIn     (dataIn),
    .sampleValid(sampleValid),
    .sampleData (sampleData)
  );

endmodule

// File: tb/adc_read_seq_bench.sv
`timescale 1ns/1ps
module adc_read_seq_bench;

  localparam int CLK_NS = 10;
  // cycle counts worked out from the nanosecond defaults (R13)
  localparam int STB_C  = (15 + CLK_NS - 1) / CLK_NS;
  localparam int BSEL_C = (40 + CLK_NS - 1) / CLK_NS;
  localparam int NORM_C = (1250 + CLK_NS - 1) / CLK_NS;
  localparam int FAST_C = (1000 + CLK_NS - 1) / CLK_NS;
  localparam int MAXG_C = (3000 + CLK_NS - 1) / CLK_NS;
  localparam int BUSY_NS = 605;
  localparam int BUSY_C = (BUSY_NS + CLK_NS - 1) / CLK_NS;

  localparam logic [15:0] JUNK  = 16'hE71B;
  localparam logic [15:0] FIRST = 16'h5A5A;

  // {fastMode, byteMode, code}: code is converted, then read back in that mode
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h1234},
    {1'b0, 1'b1, 16'hABCD},
    {1'b1, 1'b0, 16'h0001},
    {1'b1, 1'b1, 16'hFF00},
    {1'b0, 1'b1, 16'h8000},
    {1'b1, 1'b0, 16'h7FFE}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        byteMode = 1'b0;
  logic        fastMode = 1'b0;
  logic        busyEn = 1'b0;
  logic        busy = 1'b0;
  logic [15:0] dataIn = JUNK;
  logic        cnvRdN;
  logic        byteSel;
  logic        sampleValid;
  logic [15:0] sampleData;
  logic        intervalErr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  adc_read_seq u_adc_read_seq (
    .clk(clk), .rstN(rstN), .enable(enable), .byteMode(byteMode),
    .fastMode(fastMode), .busyEn(busyEn), .busy(busy), .dataIn(dataIn),
    .cnvRdN(cnvRdN), .byteSel(byteSel), .sampleValid(sampleValid),
    .sampleData(sampleData), .intervalErr(intervalErr)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] codeAt(input int i);
    if (i < NV) return VEC[i][15:0];
    return 16'h3C00 + 16'(i) * 16'h0111;
  endfunction

  // ---------------- converter model ----------------
  int          strobeIdx = 0;
  logic [15:0] held = JUNK;
  time         readyAt = 0;
  time         fallT = 0;
  bit          haveFall = 1'b0;

  always @(negedge cnvRdN) begin
    held = (strobeIdx == 0) ? FIRST : codeAt(strobeIdx - 1);
    strobeIdx++;
    fallT = $time;
    haveFall = 1'b1;
    if ($time + 12 > readyAt) readyAt = $time + 12;
  end

  always @(byteSel) begin
    if ($time + 35 > readyAt) readyAt = $time + 35;
  end

  always #1 begin
    if ($time >= readyAt)
      dataIn = byteMode ? {8'hC3, (byteSel ? held[15:8] : held[7:0])} : held;
    else
      dataIn = JUNK;
    busy = haveFall && ($time >= fallT + 5) && ($time < fallT + BUSY_NS);
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic waitFall(output int fc);
    int n = 0;
    fc = -1;
    while (n < 2000) begin
      @(negedge clk);
      if (!cnvRdN) begin
        fc = cyc;
        break;
      end
      n++;
    end
    chk(fc >= 0, "R12", "strobe expected", 32'(n), 32'd0);
  endtask

  // called at the negedge where cnvRdN is first seen low
  task automatic doRead(input bit modeByte, input bit expValid,
                        input logic [15:0] expWord, input string ctx);
    chk(byteSel == modeByte, modeByte ? "R4" : "R5", {ctx, " sel at fall"},
        32'(byteSel), 32'(modeByte));
    if (!modeByte) begin
      for (int k = 1; k < STB_C; k++) begin
        @(negedge clk);
        chk(!cnvRdN && !sampleValid && !byteSel, "R3", {ctx, " strobe held"},
            {29'd0, cnvRdN, sampleValid, byteSel}, 32'd0);
      end
      @(negedge clk);
      chk(cnvRdN, "R3 R13", {ctx, " strobe release"}, 32'(cnvRdN), 32'd1);
      chk(!byteSel, "R5", {ctx, " sel held low"}, 32'(byteSel), 32'd0);
      chk(sampleValid == expValid, expValid ? "R3" : "R2", {ctx, " valid"},
          32'(sampleValid), 32'(expValid));
      if (expValid)
        chk(sampleData == expWord, "R1", {ctx, " word"}, 32'(sampleData), 32'(expWord));
    end else begin
      for (int k = 1; k < STB_C; k++) begin
        @(negedge clk);
        chk(!cnvRdN && byteSel, "R4", {ctx, " high phase"},
            {30'd0, cnvRdN, byteSel}, 32'd1);
      end
      @(negedge clk);
      chk(!cnvRdN && !byteSel && !sampleValid, "R4 R13", {ctx, " select drop"},
          {29'd0, cnvRdN, byteSel, sampleValid}, 32'd0);
      for (int k = 1; k < BSEL_C; k++) begin
        @(negedge clk);
        chk(!cnvRdN && !byteSel && !sampleValid, "R4", {ctx, " low phase"},
            {29'd0, cnvRdN, byteSel, sampleValid}, 32'd0);
      end
      @(negedge clk);
      chk(cnvRdN && byteSel, "R4", {ctx, " release"}, {30'd0, cnvRdN, byteSel}, 32'd3);
      chk(sampleValid == expValid, expValid ? "R4" : "R2", {ctx, " valid"},
          32'(sampleValid), 32'(expValid));
      if (expValid)
        chk(sampleData == expWord, "R1", {ctx, " assembled"}, 32'(sampleData), 32'(expWord));
    end
    @(negedge clk);
    chk(!sampleValid, "R10", {ctx, " pulse width"}, 32'(sampleValid), 32'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * CLK_NS);
    chk(1'b0, "WDOG", "run timed out", 32'(cyc), 32'd0);
    finishRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    int fc;
    int prevFc;
    int lows;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk(cnvRdN && !byteSel && !sampleValid && !intervalErr && sampleData == 16'h0,
        "R11", "reset state",
        {12'd0, sampleData, cnvRdN, byteSel, sampleValid, intervalErr}, 32'h8);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    enable = 1'b1;

    // table walk: strobe i reads code i-1 and starts code i
    prevFc = 0;
    for (int i = 0; i <= NV; i++) begin
      bit rdByte;
      bit rdFast;
      waitFall(fc);
      rdByte = (i == 0) ? 1'b0 : VEC[i-1][16];
      rdFast = (i == 0) ? 1'b0 : VEC[i-1][17];
      if (i > 0)
        chk(fc - prevFc == (rdFast ? FAST_C : NORM_C), rdFast ? "R7" : "R6",
            "strobe spacing", 32'(fc - prevFc), 32'(rdFast ? FAST_C : NORM_C));
      if (i == NV) enable = 1'b0;
      doRead(rdByte, i > 0, (i > 0) ? codeAt(i - 1) : 16'h0, $sformatf("vec%0d", i));
      if (i < NV) begin
        byteMode = VEC[i][16];
        fastMode = VEC[i][17];
      end
      prevFc = fc;
    end

    // R9 / R12: fast mode, strobes held off
    lows = 0;
    while (cyc < fc + MAXG_C + 1) begin
      @(negedge clk);
      if (!cnvRdN) lows++;
      if (cyc == fc + MAXG_C)
        chk(!intervalErr, "R9", "flag before limit", 32'(intervalErr), 32'd0);
    end
    chk(intervalErr, "R9", "flag past limit", 32'(intervalErr), 32'd1);
    chk(lows == 0, "R12", "no strobe while disabled", 32'(lows), 32'd0);

    enable = 1'b1;
    waitFall(fc);
    chk(!intervalErr, "R9", "flag cleared by strobe", 32'(intervalErr), 32'd1 - 32'd1);
    fastMode = 1'b0;
    enable = 1'b0;
    doRead(1'b0, 1'b1, codeAt(NV), "resume");

    // R9: normal mode never flags a long gap
    repeat (MAXG_C + 10) @(negedge clk);
    chk(!intervalErr, "R9", "no flag in normal mode", 32'(intervalErr), 32'd0);

    // R8: busy-paced strobes
    enable = 1'b1;
    waitFall(fc);
    busyEn = 1'b1;
    doRead(1'b0, 1'b1, codeAt(NV + 1), "prebusy");
    prevFc = fc;
    waitFall(fc);
    chk(fc - prevFc == BUSY_C, "R8", "busy spacing", 32'(fc - prevFc), 32'(BUSY_C));
    doRead(1'b0, 1'b1, codeAt(NV + 2), "busy");

    finishRun();
  end

endmodule